// File: doc/BRIEF.md
# Ring Command Packet Decoder

The decoder takes 32-bit command dwords from a ring fetch unit over a valid/ready channel and turns them into either register writes or opcode dispatches. Each packet starts with a header dword. Its two top bits select one of four packet kinds:

- a burst of writes to consecutive registers;
- a write to two independently addressed registers;
- a filler that carries nothing;
- an opcode packet whose payload dwords are forwarded to an execution engine.

Register writes leave on a write port that carries a dword register index and the data. Opcode payload leaves on a separate port that carries the 8-bit opcode, the data and a last-dword flag. Payload dwords pass straight through from input to output in the same cycle. The decoder holds only the header context: state, current index, remaining count and opcode. When the output that a payload dword is bound for is not ready, the input stalls.

Top module: `cmd_pkt_decoder`

## Requirements
- R1: After reset, `dw_ready_o` is high and neither `wr_valid_o` nor `op_valid_o` is asserted.
- R2: Header bits 31:30 select the packet kind: 0 is a register burst, 1 is a register pair, 2 is filler, 3 is an opcode packet. No other header bits change how the kind is chosen.
- R3: A kind-0 header with count n (bits 29:16) is followed by n+1 data dwords. They are written to register indices starting at bits 10:0 and rising by one per dword.
- R4: A kind-0 header with count 0 produces exactly one write. The dword after that write is parsed as a new header.
- R5: A kind-1 header is followed by exactly two data dwords. The first is written to the index in bits 10:0 and the second to the index in bits 21:11.
- R6: A kind-2 header produces no output. The next dword is parsed as a header, whatever value bits 29:0 of the filler hold.
- R7: A kind-3 header with opcode in bits 15:8 and count n forwards n+1 payload dwords on the opcode port with that opcode. `op_last_o` is set on the final payload dword only, and the decoder then returns to header parsing.
- R8: While a payload dword is presented and its target output is not ready, `dw_ready_o` is low and the output index or opcode holds steady until the transfer completes.
- R9: Burst register indices wrap modulo 2048: index 0x7FF is followed by index 0x000.
- R10: Header dwords never appear on either output. In header state, a header is accepted whatever the two output ready inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dw_valid_i | input | 1 | Command dword valid |
| dw_data_i | input | 32 | Command dword |
| dw_ready_o | output | 1 | Command dword accepted when high with valid |
| wr_valid_o | output | 1 | Register write valid |
| wr_idx_o | output | 11 | Register dword index |
| wr_data_o | output | 32 | Register write data |
| wr_ready_i | input | 1 | Register write sink ready |
| op_valid_o | output | 1 | Opcode payload valid |
| op_code_o | output | 8 | Opcode of the current packet |
| op_data_o | output | 32 | Opcode payload dword |
| op_last_o | output | 1 | Final payload dword of the packet |
| op_ready_i | input | 1 | Opcode sink ready |

## Verification
Two cases are hard to reach from the ports. The first is a stall in the middle of a burst that crosses the top of the index space, where the held index and the wrapped index must both come out right. The second is a header that arrives while both sinks refuse data. The stimulus randomizes both ready inputs on every cycle while bursts, pairs, fillers and opcode packets are streamed back to back, and one burst starts two below the top index. A separate phase forces both readies low and then presents a filler header, to show that the header is taken anyway.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  typedef enum logic [1:0] {
    PKT_BURST = 2'd0,
    PKT_PAIR  = 2'd1,
    PKT_FILL  = 2'd2,
    PKT_OPC   = 2'd3
  } pkt_kind_e;

  typedef enum logic [2:0] {
    ST_HDR    = 3'd0,
    ST_BURST  = 3'd1,
    ST_PAIR_A = 3'd2,
    ST_PAIR_B = 3'd3,
    ST_OPC    = 3'd4
  } dec_state_e;
endpackage

// File: rtl/cpd_hdr_dec.sv
module cpd_hdr_dec
  import cpd_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IDX_W = 11,
  parameter int CNT_W = 14,
  parameter int OPC_W = 8
) (
  input  logic [DW-1:0]    hdr_i,
  output pkt_kind_e        kind_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [IDX_W-1:0] idx_a_o,
  output logic [IDX_W-1:0] idx_b_o,
  output logic [OPC_W-1:0] opc_o
);
  localparam int KindLsb = DW - 2;
  localparam int CntLsb  = KindLsb - CNT_W;
  localparam int OpcLsb  = CntLsb - OPC_W;

  assign kind_o  = pkt_kind_e'(hdr_i[KindLsb +: 2]);
  assign cnt_o   = hdr_i[CntLsb +: CNT_W];
  assign idx_a_o = hdr_i[0 +: IDX_W];
  assign idx_b_o = hdr_i[IDX_W +: IDX_W];
  assign opc_o   = hdr_i[OpcLsb +: OPC_W];
endmodule

// File: rtl/cpd_seq.sv
module cpd_seq
  import cpd_pkg::*;
#(
  parameter int IDX_W = 11,
  parameter int CNT_W = 14,
  parameter int OPC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  pkt_kind_e        kind_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [IDX_W-1:0] idx_a_i,
  input  logic [IDX_W-1:0] idx_b_i,
  input  logic [OPC_W-1:0] opc_i,
  output dec_state_e       state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [OPC_W-1:0] opc_o,
  output logic             last_o
);
  dec_state_e       st_q;
  logic [IDX_W-1:0] idx_q, idx_b_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OPC_W-1:0] opc_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_HDR;
      idx_q   <= '0;
      idx_b_q <= '0;
      cnt_q   <= '0;
      opc_q   <= '0;
    end else if (fire_i) begin
      unique case (st_q)
        ST_HDR: begin
          unique case (kind_i)
            PKT_BURST: begin
              st_q  <= ST_BURST;
              idx_q <= idx_a_i;
              cnt_q <= cnt_i;
            end
            PKT_PAIR: begin
              st_q    <= ST_PAIR_A;
              idx_q   <= idx_a_i;
              idx_b_q <= idx_b_i;
            end
            PKT_OPC: begin
              st_q  <= ST_OPC;
              cnt_q <= cnt_i;
              opc_q <= opc_i;
            end
            default: st_q <= ST_HDR;  // filler
          endcase
        end
        ST_BURST: begin
          idx_q <= idx_q + 1'b1;  // wraps at 2^IDX_W
          if (cnt_zero) st_q <= ST_HDR;
          else          cnt_q <= cnt_q - 1'b1;
        end
        ST_PAIR_A: begin
          idx_q <= idx_b_q;
          st_q  <= ST_PAIR_B;
        end
        ST_PAIR_B: st_q <= ST_HDR;
        ST_OPC: begin
          if (cnt_zero) st_q <= ST_HDR;
          else          cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_HDR;
      endcase
    end
  end

  assign state_o = st_q;
  assign idx_o   = idx_q;
  assign opc_o   = opc_q;
  assign last_o  = cnt_zero;

  // R3 R9
  burst_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BURST && fire_i && !cnt_zero) |=>
      (st_q == ST_BURST && idx_q == IDX_W'($past(idx_q) + 1'b1)));

  // R8
  hold_ctx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_HDR && !fire_i) |=> ($stable(idx_q) && $stable(st_q) && $stable(opc_q)));

  // R5
  pair_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PAIR_A && fire_i) |=> (st_q == ST_PAIR_B && idx_q == $past(idx_b_q)));

  // R7
  opc_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OPC && fire_i && cnt_zero) |=> (st_q == ST_HDR));

  // R6
  fill_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HDR && fire_i && kind_i == PKT_FILL) |=> (st_q == ST_HDR));
endmodule

// File: rtl/cmd_pkt_decoder.sv
module cmd_pkt_decoder
  import cpd_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IDX_W = 11,
  parameter int CNT_W = 14,
  parameter int OPC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dw_valid_i,
  input  logic [DW-1:0]    dw_data_i,
  output logic             dw_ready_o,
  output logic             wr_valid_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [DW-1:0]    wr_data_o,
  input  logic             wr_ready_i,
  output logic             op_valid_o,
  output logic [OPC_W-1:0] op_code_o,
  output logic [DW-1:0]    op_data_o,
  output logic             op_last_o,
  input  logic             op_ready_i
);
  pkt_kind_e        h_kind;
  logic [CNT_W-1:0] h_cnt;
  logic [IDX_W-1:0] h_idx_a, h_idx_b;
  logic [OPC_W-1:0] h_opc;
  dec_state_e       st;
  logic [IDX_W-1:0] cur_idx;
  logic [OPC_W-1:0] cur_opc;
  logic             cur_last;
  logic             in_reg, in_opc, fire;

  cpd_hdr_dec #(.DW(DW), .IDX_W(IDX_W), .CNT_W(CNT_W), .OPC_W(OPC_W)) u_hdr (
    .hdr_i   (dw_data_i),
    .kind_o  (h_kind),
    .cnt_o   (h_cnt),
    .idx_a_o (h_idx_a),
    .idx_b_o (h_idx_b),
    .opc_o   (h_opc)
  );

  cpd_seq #(.IDX_W(IDX_W), .CNT_W(CNT_W), .OPC_W(OPC_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .kind_i  (h_kind),
    .cnt_i   (h_cnt),
    .idx_a_i (h_idx_a),
    .idx_b_i (h_idx_b),
    .opc_i   (h_opc),
    .state_o (st),
    .idx_o   (cur_idx),
    .opc_o   (cur_opc),
    .last_o  (cur_last)
  );

  assign in_reg = (st == ST_BURST) || (st == ST_PAIR_A) || (st == ST_PAIR_B);
  assign in_opc = (st == ST_OPC);

  assign dw_ready_o = (st == ST_HDR) || (in_reg && wr_ready_i) || (in_opc && op_ready_i);
  assign fire       = dw_valid_i && dw_ready_o;

  assign wr_valid_o = dw_valid_i && in_reg;
  assign wr_idx_o   = cur_idx;
  assign wr_data_o  = dw_data_i;

  assign op_valid_o = dw_valid_i && in_opc;
  assign op_code_o  = cur_opc;
  assign op_data_o  = dw_data_i;
  assign op_last_o  = in_opc && cur_last;

  // R8
  stall_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_valid_o && !wr_ready_i) || (op_valid_o && !op_ready_i)) |-> !dw_ready_o);

  // R10
  one_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_valid_o, op_valid_o}));

  // R8
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> $stable(wr_idx_o));
endmodule

// File: tb/cmd_pkt_decoder_bench.sv
`timescale 1ns/1ps
module cmd_pkt_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dw_valid = 1'b0;
  logic [31:0] dw_data = '0;
  logic        dw_ready;
  logic        wr_valid, wr_ready;
  logic [10:0] wr_idx;
  logic [31:0] wr_data;
  logic        op_valid, op_ready, op_last;
  logic [7:0]  op_code;
  logic [31:0] op_data;

  int n_chk = 0;
  int n_fail = 0;
  int bp_mode = 0;  // 0 all ready, 1 random, 2 all stalled
  bit done = 0;

  typedef struct {
    bit          is_op;
    logic [10:0] idx;
    logic [7:0]  opc;
    logic [31:0] data;
    bit          last;
    string       req;
  } exp_t;
  exp_t expq[$];

  always #2.5 clk = ~clk;

  cmd_pkt_decoder u_cmd_pkt_decoder (
    .clk_i(clk), .rst_ni(rst_n),
    .dw_valid_i(dw_valid), .dw_data_i(dw_data), .dw_ready_o(dw_ready),
    .wr_valid_o(wr_valid), .wr_idx_o(wr_idx), .wr_data_o(wr_data), .wr_ready_i(wr_ready),
    .op_valid_o(op_valid), .op_code_o(op_code), .op_data_o(op_data),
    .op_last_o(op_last), .op_ready_i(op_ready)
  );

  task automatic chk(input bit ok, input string req, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  always @(negedge clk) begin
    case (bp_mode)
      1: begin wr_ready = $urandom_range(0, 1) == 1; op_ready = $urandom_range(0, 1) == 1; end
      2: begin wr_ready = 1'b0; op_ready = 1'b0; end
      default: begin wr_ready = 1'b1; op_ready = 1'b1; end
    endcase
  end

  // monitor / scoreboard
  bit          prev_wstall = 0, prev_ostall = 0;
  logic [10:0] prev_idx;
  logic [7:0]  prev_opc;
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      if (prev_wstall)
        chk(wr_valid && wr_idx == prev_idx, "R8",
            $sformatf("held idx act=%h exp=%h", wr_idx, prev_idx));
      if (prev_ostall)
        chk(op_valid && op_code == prev_opc, "R8",
            $sformatf("held opc act=%h exp=%h", op_code, prev_opc));
      if ((wr_valid && !wr_ready) || (op_valid && !op_ready))
        chk(!dw_ready, "R8", $sformatf("ready act=%b exp=0", dw_ready));
      if (wr_valid && op_valid) chk(0, "R10", "both outputs valid act=11 exp=0x");
      if ((wr_valid && wr_ready) || (op_valid && op_ready)) begin
        if (expq.size() == 0) begin
          chk(0, "R10", $sformatf("unexpected output data act=%h exp=none",
                                   wr_valid ? wr_data : op_data));
        end else begin
          exp_t e;
          e = expq.pop_front();
          if (e.is_op)
            chk(op_valid && op_code == e.opc && op_data == e.data && op_last == e.last, e.req,
                $sformatf("op act=%b/%h/%h/%b exp=1/%h/%h/%b",
                          op_valid, op_code, op_data, op_last, e.opc, e.data, e.last));
          else
            chk(wr_valid && wr_idx == e.idx && wr_data == e.data, e.req,
                $sformatf("wr act=%b/%h/%h exp=1/%h/%h",
                          wr_valid, wr_idx, wr_data, e.idx, e.data));
        end
      end
      prev_wstall = wr_valid && !wr_ready;
      prev_ostall = op_valid && !op_ready;
      prev_idx    = wr_idx;
      prev_opc    = op_code;
    end
  end

  task automatic send(input logic [31:0] d);
    dw_valid = 1'b1;
    dw_data  = d;
    forever begin
      #2;
      if (dw_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    dw_valid = 1'b0;
  endtask

  task automatic push_wr(input logic [10:0] idx, input logic [31:0] d, input string req);
    exp_t e;
    e.is_op = 0; e.idx = idx; e.opc = '0; e.data = d; e.last = 0; e.req = req;
    expq.push_back(e);
  endtask

  task automatic pkt_burst(input logic [10:0] idx, input logic [13:0] n, input string req);
    send({2'd0, n, 5'h15, idx});
    for (int i = 0; i <= int'(n); i++) begin
      logic [31:0] d;
      d = 32'hB000_0000 ^ (idx << 8) ^ i;
      push_wr(idx + 11'(i), d, req);
      send(d);
    end
  endtask

  task automatic pkt_pair(input logic [10:0] a, input logic [10:0] b);
    send({2'd1, 8'hA5, b, a});
    push_wr(a, 32'hCAFE_0001, "R5");
    send(32'hCAFE_0001);
    push_wr(b, 32'hCAFE_0002, "R5");
    send(32'hCAFE_0002);
  endtask

  task automatic pkt_opc(input logic [7:0] opc, input logic [13:0] n);
    send({2'd3, n, opc, 8'h5A});
    for (int i = 0; i <= int'(n); i++) begin
      exp_t e;
      e.is_op = 1; e.idx = '0; e.opc = opc; e.data = 32'hD000_0000 + {opc, 16'h0} + i;
      e.last = (i == int'(n)); e.req = "R7";
      expq.push_back(e);
      send(e.data);
    end
  endtask

  task automatic drain;
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R2", $sformatf("pending items act=%0d exp=0", expq.size()));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R1
    chk(dw_ready && !wr_valid && !op_valid, "R1",
        $sformatf("reset act=%b%b%b exp=100", dw_ready, wr_valid, op_valid));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    pkt_burst(11'h010, 14'd3, "R3");
    pkt_burst(11'h5C8, 14'd0, "R4");
    pkt_pair(11'h123, 11'h7FE);   // R4: header right after single write
    send(32'h8ABC_1234);          // R6 filler
    send(32'hBFFF_FFFF);          // R6 filler, all low bits set
    pkt_burst(11'h040, 14'd1, "R6");
    pkt_opc(8'h9B, 14'd2);
    pkt_opc(8'h23, 14'd0);
    pkt_burst(11'h7FE, 14'd3, "R9");
    drain();

    bp_mode = 1;
    for (int k = 0; k < 12; k++) begin
      pkt_burst(11'h7FD, 14'(k % 5), "R9");
      send(32'h8000_0000);
      pkt_pair(11'(k), 11'(k + 100));
      pkt_opc(8'h94, 14'(k % 4));
      pkt_opc(8'h9A, 14'd0);
      pkt_burst(11'(k * 3), 14'd0, "R4");
    end
    drain();

    // R10: header taken while both sinks stall
    bp_mode = 2;
    @(negedge clk);
    dw_valid = 1'b1;
    dw_data  = 32'h8000_0001;
    #2;
    chk(dw_ready, "R10", $sformatf("hdr ready act=%b exp=1", dw_ready));
    @(negedge clk);
    dw_valid = 1'b0;
    bp_mode = 0;
    pkt_opc(8'h23, 14'd1);
    drain();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule